// File: doc/BRIEF.md
# Seven-to-One Pixel Lane Serializer

This block takes one parallel pixel (8-bit red, green and blue, plus horizontal sync, vertical sync and a data-valid flag) and sends it as seven serial bit slots on up to four data lanes, together with a clock lane that marks the word boundary. It runs on a bit clock at seven times the pixel rate. A free-running modulo-7 slot counter decides when a new pixel is taken. A pixel is taken only at slot 0. The layout selection and the order flag are taken at the same moment, so every seven-bit word is built from one consistent set of settings.

Three lane layouts are available at run time: an 18-bit layout on three lanes, and two 24-bit layouts on four lanes. One 24-bit layout puts the two least significant bits of each colour on the fourth lane. The other puts the two most significant bits there. A reversal flag sends each data lane's word from its last slot to its first. The differential buffers, the bit-clock generator and any crossing from a pixel clock domain lie outside the block.

Top module: `lvds_pixel_ser`

## Requirements
- R1: With `map_sel` = 0, lane 0 carries slots 0..6 = G0, R5, R4, R3, R2, R1, R0. Lane 1 carries B1, B0, G5, G4, G3, G2, G1. Lane 2 carries DE, VS, HS, B5, B4, B3, B2. Lane 3 stays 0, and colour bits 7 and 6 have no effect on any lane.
- R2: With `map_sel` = 1, lane 0 carries G2, R7..R2. Lane 1 carries B3, B2, G7..G3. Lane 2 carries DE, VS, HS, B7..B4. Lane 3 carries 0, B1, B0, G1, G0, R1, R0.
- R3: With `map_sel` = 2, lanes 0 to 2 follow the R1 layout. Lane 3 carries 0, B7, B6, G7, G6, R7, R6.
- R4: In every layout the control bits sit on lane 2: data-valid in slot 0, vertical sync in slot 1, horizontal sync in slot 2. Slot 0 of lane 3 is always 0.
- R5: When `mirror_en` is 1 at the capture point, each data lane emits slot 6 first and slot 0 last.
- R6: The clock lane repeats the pattern 1,1,0,0,0,1,1 over slots 0..6, whatever the mirror flag and layout.
- R7: Pixel, `map_sel` and `mirror_en` are sampled only at the slot-0 edge. Changes during slots 1..6 do not alter the word being sent.
- R8: While `rst` is high, all data lanes and the clock lane read 0 after the next edge. The first edge after reset captures the inputs and drives slot 0, so each output shows the slot of the edge before it.
- R9: `map_sel` = 3 behaves exactly like `map_sel` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, seven times the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| pix_r | input | 8 | Red component |
| pix_g | input | 8 | Green component |
| pix_b | input | 8 | Blue component |
| hsync | input | 1 | Horizontal sync |
| vsync | input | 1 | Vertical sync |
| den | input | 1 | Data valid |
| map_sel | input | 2 | Layout select: 0 18-bit, 1 24-bit low bits on lane 3, 2 24-bit high bits on lane 3, 3 as 0 |
| mirror_en | input | 1 | Reverse slot order on the data lanes |
| lane_o | output | 4 | Serial data lanes 0..3 |
| clk_lane_o | output | 1 | Serial clock-lane bit |

## Verification
A slot counter that is out of step shows at once: within one word the clock lane breaks its 1,1,0,0,0,1,1 rhythm, and the data bits land in neighbouring slots. A layout or order register that is wrong or latched at the wrong edge corrupts the very next word on at least one lane. A capture that misses the slot-0 edge lets changes made in the middle of a word leak into the current word, which shows within the seven cycles of that word.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;

    localparam int SLOTS     = 7;
    localparam int NUM_LANES = 4;
    localparam int COLOR_W   = 8;
    localparam int SLOT_W    = $clog2(SLOTS);

    // clock lane level per slot, bit index = slot
    localparam logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011;

    typedef enum logic [1:0] {
        MAP_NARROW = 2'd0,
        MAP_WIDE_LO = 2'd1,
        MAP_WIDE_HI = 2'd2,
        MAP_SPARE   = 2'd3
    } map_mode_e;

    typedef struct packed {
        logic [COLOR_W-1:0] r;
        logic [COLOR_W-1:0] g;
        logic [COLOR_W-1:0] b;
        logic               hs;
        logic               vs;
        logic               de;
    } pixel_t;

    typedef logic [NUM_LANES-1:0][SLOTS-1:0] lane_words_t;

    function automatic map_mode_e fold_mode(input logic [1:0] sel);
        map_mode_e m;
        m = map_mode_e'(sel);
        if (m == MAP_SPARE) m = MAP_NARROW;
        return m;
    endfunction

    // word bit index equals slot number
    function automatic lane_words_t map_pixel(input pixel_t p, input map_mode_e m);
        lane_words_t w;
        w = '0;
        if (m == MAP_WIDE_LO) begin
            w[0] = {p.r[2], p.r[3], p.r[4], p.r[5], p.r[6], p.r[7], p.g[2]};
            w[1] = {p.g[3], p.g[4], p.g[5], p.g[6], p.g[7], p.b[2], p.b[3]};
            w[2] = {p.b[4], p.b[5], p.b[6], p.b[7], p.hs, p.vs, p.de};
            w[3] = {p.r[0], p.r[1], p.g[0], p.g[1], p.b[0], p.b[1], 1'b0};
        end else begin
            w[0] = {p.r[0], p.r[1], p.r[2], p.r[3], p.r[4], p.r[5], p.g[0]};
            w[1] = {p.g[1], p.g[2], p.g[3], p.g[4], p.g[5], p.b[0], p.b[1]};
            w[2] = {p.b[2], p.b[3], p.b[4], p.b[5], p.hs, p.vs, p.de};
            if (m == MAP_WIDE_HI)
                w[3] = {p.r[6], p.r[7], p.g[6], p.g[7], p.b[6], p.b[7], 1'b0};
        end
        return w;
    endfunction

endpackage

// File: rtl/lvds_slot_ctr.sv
module lvds_slot_ctr
    import lvds_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [SLOT_W-1:0] slot,
    output logic              at_first
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    always_ff @(posedge clk) begin
        if (rst)               slot <= '0;
        else if (slot == LAST) slot <= '0;
        else                   slot <= slot + 1'b1;
    end

    assign at_first = (slot == '0);
endmodule

// File: rtl/lvds_word_latch.sv
module lvds_word_latch
    import lvds_ser_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  pixel_t      pix,
    input  logic [1:0]  sel,
    input  logic        mirror,
    output lane_words_t words_now,
    output logic        mirror_now
);
    lane_words_t fresh;
    lane_words_t held;
    logic        mir_held;

    assign fresh = map_pixel(pix, fold_mode(sel));

    always_ff @(posedge clk) begin
        if (rst) begin
            held     <= '0;
            mir_held <= 1'b0;
        end else if (load) begin
            held     <= fresh;
            mir_held <= mirror;
        end
    end

    // at slot 0 the fresh word is used directly so slot 0 leaves on the capture edge
    assign words_now  = load ? fresh  : held;
    assign mirror_now = load ? mirror : mir_held;
endmodule

// File: rtl/lvds_lane_out.sv
module lvds_lane_out
    import lvds_ser_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SLOT_W-1:0]    slot,
    input  lane_words_t          words,
    input  logic                 mirror,
    output logic [NUM_LANES-1:0] lanes,
    output logic                 clk_lane
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    logic [SLOT_W-1:0] pick;
    assign pick = mirror ? (LAST - slot) : slot;

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) lanes[i] <= 1'b0;
            else     lanes[i] <= words[i][pick];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) clk_lane <= 1'b0;
        else     clk_lane <= CLK_PATTERN[slot];
    end
endmodule

// File: rtl/lvds_pixel_ser.sv
module lvds_pixel_ser
    import lvds_ser_pkg::*;
(
    input  logic                 clk_bit,
    input  logic                 rst,
    input  logic [COLOR_W-1:0]   pix_r,
    input  logic [COLOR_W-1:0]   pix_g,
    input  logic [COLOR_W-1:0]   pix_b,
    input  logic                 hsync,
    input  logic                 vsync,
    input  logic                 den,
    input  logic [1:0]           map_sel,
    input  logic                 mirror_en,
    output logic [NUM_LANES-1:0] lane_o,
    output logic                 clk_lane_o
);
    logic [SLOT_W-1:0] slot;
    logic              at_first;
    pixel_t            pix;
    lane_words_t       words_now;
    logic              mirror_now;

    assign pix = '{r: pix_r, g: pix_g, b: pix_b, hs: hsync, vs: vsync, de: den};

    lvds_slot_ctr u_ctr (
        .clk      (clk_bit),
        .rst      (rst),
        .slot     (slot),
        .at_first (at_first)
    );

    lvds_word_latch u_latch (
        .clk        (clk_bit),
        .rst        (rst),
        .load       (at_first),
        .pix        (pix),
        .sel        (map_sel),
        .mirror     (mirror_en),
        .words_now  (words_now),
        .mirror_now (mirror_now)
    );

    lvds_lane_out u_out (
        .clk      (clk_bit),
        .rst      (rst),
        .slot     (slot),
        .words    (words_now),
        .mirror   (mirror_now),
        .lanes    (lane_o),
        .clk_lane (clk_lane_o)
    );
endmodule

// File: rtl/lvds_pixel_ser_chk.sv
module lvds_pixel_ser_chk
    import lvds_ser_pkg::*;
(
    input logic                 clk_bit,
    input logic                 rst,
    input logic [1:0]           map_sel,
    input logic                 mirror_en,
    input logic [NUM_LANES-1:0] lane_o,
    input logic                 clk_lane_o
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    logic [SLOT_W-1:0] nxt_slot;
    logic [SLOT_W-1:0] shown;
    logic              live;
    logic [1:0]        cap_mode;
    logic              cap_mir;

    always_ff @(posedge clk_bit) begin
        if (rst) begin
            nxt_slot <= '0;
            shown    <= '0;
            live     <= 1'b0;
            cap_mode <= 2'd0;
            cap_mir  <= 1'b0;
        end else begin
            nxt_slot <= (nxt_slot == LAST) ? '0 : nxt_slot + 1'b1;
            shown    <= nxt_slot;
            live     <= 1'b1;
            if (nxt_slot == '0) begin
                cap_mode <= map_sel;
                cap_mir  <= mirror_en;
            end
        end
    end

    // R8
    reset_clears_chk: assert property (@(posedge clk_bit)
        rst |=> (lane_o == '0 && !clk_lane_o));

    // R6
    clock_pattern_chk: assert property (@(posedge clk_bit) disable iff (rst)
        live |-> (clk_lane_o == CLK_PATTERN[shown]));

    // R1
    narrow_lane3_idle_chk: assert property (@(posedge clk_bit) disable iff (rst)
        (live && (cap_mode == 2'd0 || cap_mode == 2'd3)) |-> !lane_o[3]);

    // R4
    ctl3_zero_chk: assert property (@(posedge clk_bit) disable iff (rst)
        (live && ((shown == '0 && !cap_mir) || (shown == LAST && cap_mir))) |-> !lane_o[3]);
endmodule

bind lvds_pixel_ser lvds_pixel_ser_chk u_chk (
    .clk_bit    (clk_bit),
    .rst        (rst),
    .map_sel    (map_sel),
    .mirror_en  (mirror_en),
    .lane_o     (lane_o),
    .clk_lane_o (clk_lane_o)
);

// File: tb/lvds_pixel_ser_tb.sv
module lvds_pixel_ser_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pr = '0, pg = '0, pb = '0;
    logic       hs = 1'b0, vs = 1'b0, de = 1'b0;
    logic [1:0] msel = 2'd0;
    logic       mir = 1'b0;
    logic [3:0] lanes;
    logic       clane;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lvds_pixel_ser u_dut (
        .clk_bit (clk), .rst (rst),
        .pix_r (pr), .pix_g (pg), .pix_b (pb),
        .hsync (hs), .vsync (vs), .den (de),
        .map_sel (msel), .mirror_en (mir),
        .lane_o (lanes), .clk_lane_o (clane)
    );

    // vector: [7:0] red, [15:8] green, [23:16] blue, 24 hsync, 25 vsync, 26 data valid
    function automatic logic [6:0] exp_word(input int mode, input int lane, input logic [26:0] v);
        logic [7:0] r, g, b;
        logic [6:0] w;
        int m;
        r = v[7:0]; g = v[15:8]; b = v[23:16];
        m = (mode == 3) ? 0 : mode;
        w = '0;
        case (lane)
            0: begin
                w[0] = (m == 1) ? g[2] : g[0];
                for (int s = 1; s < 7; s++) w[s] = (m == 1) ? r[8-s] : r[6-s];
            end
            1: begin
                w[0] = (m == 1) ? b[3] : b[1];
                w[1] = (m == 1) ? b[2] : b[0];
                for (int s = 2; s < 7; s++) w[s] = (m == 1) ? g[9-s] : g[7-s];
            end
            2: begin
                w[0] = v[26]; w[1] = v[25]; w[2] = v[24];
                for (int s = 3; s < 7; s++) w[s] = (m == 1) ? b[10-s] : b[8-s];
            end
            default: begin
                if (m == 1) w[6:1] = {r[0], r[1], g[0], g[1], b[0], b[1]};
                if (m == 2) w[6:1] = {r[6], r[7], g[6], g[7], b[6], b[7]};
            end
        endcase
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [26:0] v, input int mode, input bit m);
        pr = v[7:0]; pg = v[15:8]; pb = v[23:16];
        hs = v[24]; vs = v[25]; de = v[26];
        msel = 2'(mode); mir = m;
    endtask

    // called at a negedge with the slot counter at 0; leaves at a negedge with it at 0 again
    task automatic send(input logic [26:0] v, input int mode, input bit m,
                        input bit scramble, input string req);
        logic [6:0] w [4];
        logic [6:0] pat;
        int idx;
        pat = 7'b1100011;
        for (int l = 0; l < 4; l++) w[l] = exp_word(mode, l, v);
        drive(v, mode, m);
        for (int s = 0; s < 7; s++) begin
            @(posedge clk);
            @(negedge clk);
            idx = m ? 6 - s : s;
            for (int l = 0; l < 4; l++)
                check(scramble ? "R7" : (m ? "R5" : req), 32'(lanes[l]), 32'(w[l][idx]));
            check("R6", 32'(clane), 32'(pat[s]));
            if (scramble) drive(~v, (mode + 1) % 4, ~m);
        end
    endtask

    function automatic string mode_req(input int mode);
        case (mode)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            default: return "R9";
        endcase
    endfunction

    initial begin
        logic [26:0] seed;
        seed = 27'h2a5_c3e1;
        drive(27'h7ff_ffff, 1, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8 reset state
        check("R8", 32'(lanes), 32'd0);
        check("R8", 32'(clane), 32'd0);
        rst = 1'b0;

        for (int mode = 0; mode < 4; mode++) begin
            for (int m = 0; m < 2; m++) begin
                for (int k = 0; k < 27; k++)
                    send(27'(1) << k, mode, m[0], 1'b0, mode_req(mode));
                send(27'h555_5555, mode, m[0], 1'b0, mode_req(mode));
                send(27'h2aa_aaaa, mode, m[0], 1'b0, mode_req(mode));
                for (int k = 0; k < 12; k++) begin
                    seed = seed * 27'd1103 + 27'd12345;
                    send(seed, mode, m[0], k[0], mode_req(mode));
                end
            end
        end

        // R4 control bits alone in each layout
        for (int mode = 0; mode < 3; mode++)
            for (int c = 0; c < 8; c++)
                send({3'(c), 24'h0}, mode, 1'b0, 1'b0, "R4");

        // R1 upper colour bits alone give all-zero lanes in the narrow layout
        send(27'h0c0_c0c0, 0, 1'b0, 1'b0, "R1");

        // R8 reset in the middle of a word, then restart at slot 0
        send(27'h123_4567, 2, 1'b0, 1'b0, "R3");
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R8", 32'(lanes), 32'd0);
        check("R8", 32'(clane), 32'd0);
        rst = 1'b0;
        send(27'h6db_6db6, 1, 1'b0, 1'b0, "R8");
        send(27'h6db_6db6, 1, 1'b1, 1'b0, "R8");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=finish", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule